// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for three indexed addressing modes of an 8-bit processor with a 16-bit address space. The opcode decoder marks the start of an instruction with a one-cycle `op_start` pulse and supplies a 2-bit mode code at the same time. The operand bytes that follow the opcode then arrive one per `opnd_valid` pulse. The block shifts them into an offset and adds that offset to either the 16-bit index register or the stack pointer. When the last byte the mode needs has been taken, it presents the sum on `ea_addr` with a one-cycle `ea_valid` strobe.

The first mode, offset-8 with post-increment, uses one unsigned offset byte added to the index register. After the memory access is reported done, the block writes the index register back incremented by one, using `idx_we` and `idx_wdata`. The offset-16 mode takes the high byte first and then the low byte, and adds the 16-bit offset to the index register. The stack mode adds one unsigned byte to the stack pointer. Any further operand bytes of the same instruction are ignored. Opcode decoding, the memory access itself and any compare-and-branch logic lie outside this block.

Top module: `idx_ea_gen`

## Requirements
- R1: Synchronous active-high reset clears `ea_valid` and `idx_we` and disarms the byte sequencer. Operand bytes that arrive after reset without an `op_start` produce no output.
- R2: Mode code 1 (offset-8, post-increment): `ea_addr` equals `idx_in` plus the zero-extended first operand byte. `ea_valid` is high in the cycle after the edge that takes that byte.
- R3: Mode code 2 (offset-16): the first operand byte is the offset's high byte and the second is its low byte. `ea_addr` equals `idx_in` plus that offset, and `ea_valid` is high in the cycle after the edge that takes the second byte.
- R4: Mode code 3 (stack): `ea_addr` equals `stkp_in` plus the zero-extended first operand byte, even when `idx_in` differs from `stkp_in`.
- R5: Every sum, including the post-increment, is taken modulo 65536 and has no carry out.
- R6: `ea_valid` is high for exactly one cycle per instruction. Operand bytes beyond the count the mode needs are ignored.
- R7: In mode 1, the first `access_done` pulse at or after the cycle `ea_valid` is high causes `idx_we` to be high for one cycle in the next cycle. `idx_wdata` then equals the index value used for the address plus one, even if `idx_in` has changed since.
- R8: An `access_done` pulse in modes 2 or 3, or before the mode-1 address has been issued, causes no `idx_we`.
- R9: Mode code 0 arms nothing. Operand bytes that follow it produce neither `ea_valid` nor `idx_we`.
- R10: An `op_start` pulse restarts the sequence and abandons any pending write-back. An operand byte presented in the same cycle as `op_start` is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_start | input | 1 | One-cycle pulse marking a new instruction |
| op_mode | input | 2 | Mode code sampled with `op_start` (0 none, 1 offset-8 post-increment, 2 offset-16, 3 stack) |
| idx_in | input | 16 | Current index register value |
| stkp_in | input | 16 | Current stack pointer value |
| opnd_valid | input | 1 | Operand byte strobe |
| opnd_byte | input | 8 | Operand byte, in fetch order |
| access_done | input | 1 | Pulse reporting that the operand access has finished |
| ea_addr | output | 16 | Effective address |
| ea_valid | output | 1 | One-cycle strobe qualifying `ea_addr` |
| idx_we | output | 1 | One-cycle index register write strobe |
| idx_wdata | output | 16 | Incremented index value to write back |

## Verification
The address path is exercised with bases and offsets chosen so that each error shows a distinct wrong value. Stack mode runs with `idx_in` and `stkp_in` different, so a wrong base select is visible. The offset-16 bytes differ from each other, so swapped byte order is visible. Sums near 0xFFFF show whether wrap-around is correct. Extra trailing bytes, a byte in the same cycle as `op_start`, and mode code 0 show whether the byte counter takes only what the mode needs. Write-back is checked with `access_done` placed before the address, in non-increment modes, and after `idx_in` has changed. Together these separate a correct capture of the index value from a live read of it and from a spurious write.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        EA_NONE    = 2'd0,
        EA_IDX8_PI = 2'd1,
        EA_IDX16   = 2'd2,
        EA_STK8    = 2'd3
    } ea_mode_e;

    // number of operand bytes that make up the offset for a mode
    function automatic int offset_bytes(ea_mode_e m);
        case (m)
            EA_IDX16: return 2;
            EA_NONE:  return 0;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/ea_byte_seq.sv
module ea_byte_seq
    import ea_pkg::*;
#(
    parameter int BW = 8,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_start,
    input  ea_mode_e         op_mode,
    input  logic             opnd_valid,
    input  logic [BW-1:0]    opnd_byte,
    output ea_mode_e         mode_q,
    output logic             take_last,
    output logic [NB*BW-1:0] offset
);
    localparam int OW = NB * BW;
    localparam int CW = $clog2(NB + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        ea_mode_e      mode;
        logic [OW-1:0] off;
    } seq_t;

    seq_t s_d, s_q;
    logic [OW-1:0] off_now;
    logic [CW-1:0] need;

    always_comb begin
        s_d       = s_q;
        take_last = 1'b0;
        need      = CW'(offset_bytes(s_q.mode));
        off_now   = s_q.off;
        if (op_start) begin
            s_d.armed = (op_mode != EA_NONE);
            s_d.mode  = op_mode;
            s_d.cnt   = '0;
            s_d.off   = '0;
        end else if (s_q.armed && opnd_valid) begin
            if (NB > 1) begin
                off_now = {s_q.off[OW-BW-1:0], opnd_byte};
            end else begin
                off_now = OW'(opnd_byte);
            end
            s_d.off = off_now;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt + 1'b1 == need) begin
                take_last = 1'b1;
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{armed: 1'b0, cnt: '0, mode: EA_NONE, off: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_q = s_q.mode;
    assign offset = off_now;

    // a disarmed sequencer stays disarmed until a new start (R10)
    p_stay_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!s_q.armed && !op_start) |=> !s_q.armed);

endmodule

// File: rtl/ea_sum.sv
module ea_sum
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int OW = 16
) (
    input  ea_mode_e      mode,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] stkp,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base;

    always_comb begin
        base = (mode == EA_STK8) ? stkp : idx;
        sum  = base + AW'(offset);   // modulo 2**AW
    end

endmodule

// File: rtl/ea_postinc.sv
module ea_postinc #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_start,
    input  logic          arm,
    input  logic [AW-1:0] base_idx,
    input  logic          access_done,
    output logic          idx_we,
    output logic [AW-1:0] idx_wdata
);
    typedef struct packed {
        logic          waiting;
        logic [AW-1:0] base;
        logic          we;
        logic [AW-1:0] wdata;
    } pi_t;

    pi_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.we = 1'b0;
        if (op_start) begin
            p_d.waiting = 1'b0;
        end else if (arm) begin
            p_d.waiting = 1'b1;
            p_d.base    = base_idx;
        end else if (p_q.waiting && access_done) begin
            p_d.we      = 1'b1;
            p_d.wdata   = p_q.base + 1'b1;
            p_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '{waiting: 1'b0, base: '0, we: 1'b0, wdata: '0};
        end else begin
            p_q <= p_d;
        end
    end

    assign idx_we    = p_q.we;
    assign idx_wdata = p_q.wdata;

    p_we_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> $past(access_done));

    p_we_single_r7: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> !idx_we);

    p_start_cancels_r10: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !idx_we);

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_start,
    input  logic [1:0]    op_mode,
    input  logic [AW-1:0] idx_in,
    input  logic [AW-1:0] stkp_in,
    input  logic          opnd_valid,
    input  logic [BW-1:0] opnd_byte,
    input  logic          access_done,
    output logic [AW-1:0] ea_addr,
    output logic          ea_valid,
    output logic          idx_we,
    output logic [AW-1:0] idx_wdata
);
    localparam int NB = 2;
    localparam int OW = NB * BW;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } ea_t;

    ea_mode_e      mode_q;
    logic          take_last;
    logic [OW-1:0] offset;
    logic [AW-1:0] sum;
    ea_t           e_d, e_q;

    ea_byte_seq #(.BW(BW), .NB(NB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .op_start   (op_start),
        .op_mode    (ea_mode_e'(op_mode)),
        .opnd_valid (opnd_valid),
        .opnd_byte  (opnd_byte),
        .mode_q     (mode_q),
        .take_last  (take_last),
        .offset     (offset)
    );

    ea_sum #(.AW(AW), .OW(OW)) u_sum (
        .mode   (mode_q),
        .idx    (idx_in),
        .stkp   (stkp_in),
        .offset (offset),
        .sum    (sum)
    );

    ea_postinc #(.AW(AW)) u_pi (
        .clk         (clk),
        .rst         (rst),
        .op_start    (op_start),
        .arm         (take_last && (mode_q == EA_IDX8_PI)),
        .base_idx    (idx_in),
        .access_done (access_done),
        .idx_we      (idx_we),
        .idx_wdata   (idx_wdata)
    );

    always_comb begin
        e_d       = e_q;
        e_d.valid = take_last && (mode_q != EA_NONE);
        if (take_last) begin
            e_d.addr = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '{valid: 1'b0, addr: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign ea_valid = e_q.valid;
    assign ea_addr  = e_q.addr;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ea_valid && !idx_we));

    p_ea_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> $past(opnd_valid && !op_start));

    p_ea_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    p_no_mode_none_r9: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (mode_q != EA_NONE));

endmodule

// File: tb/sim_idx_ea_gen.sv
module sim_idx_ea_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic [15:0] idx_in = 16'h0;
    logic [15:0] stkp_in = 16'h0;
    logic        opnd_valid = 1'b0;
    logic [7:0]  opnd_byte = 8'h0;
    logic        access_done = 1'b0;
    logic [15:0] ea_addr;
    logic        ea_valid;
    logic        idx_we;
    logic [15:0] idx_wdata;

    always #4 clk = ~clk;   // 125 MHz

    idx_ea_gen u0 (
        .clk(clk), .rst(rst), .op_start(op_start), .op_mode(op_mode),
        .idx_in(idx_in), .stkp_in(stkp_in), .opnd_valid(opnd_valid),
        .opnd_byte(opnd_byte), .access_done(access_done),
        .ea_addr(ea_addr), .ea_valid(ea_valid), .idx_we(idx_we),
        .idx_wdata(idx_wdata)
    );

    typedef struct {
        int          kind;   // 0 address, 1 write-back
        logic [15:0] val;
        int          due;
        string       req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(int kind, logic [15:0] v, int due, string req);
        exp_t e;
        e.kind = kind; e.val = v; e.due = due; e.req = req;
        sb.push_back(e);
    endtask

    task automatic start_op(logic [1:0] m);
        op_start = 1'b1; op_mode = m;
        tick();
        op_start = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        opnd_valid = 1'b1; opnd_byte = b;
        tick();
        opnd_valid = 1'b0;
    endtask

    task automatic send_last(logic [7:0] b, logic [15:0] exp_ea, string req);
        opnd_valid = 1'b1; opnd_byte = b;
        push(0, exp_ea, cyc + 1, req);
        tick();
        opnd_valid = 1'b0;
    endtask

    task automatic done_pulse(bit expect_we, logic [15:0] exp_wd, string req);
        access_done = 1'b1;
        if (expect_we) push(1, exp_wd, cyc + 1, req);
        tick();
        access_done = 1'b0;
    endtask

    task automatic drained(string req);
        idle(3);
        n_chk++;
        if (sb.size() != 0) begin
            n_err++;
            $display("FAIL %s: pending=%0d expected=0", req, sb.size());
            sb.delete();
        end
    endtask

    task automatic compare(int kind, logic [15:0] v);
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
            n_err++;
            $display("FAIL %s: unexpected strobe kind=%0d value=%h expected none",
                     cur_req, kind, v);
            return;
        end
        e = sb.pop_front();
        if (e.kind != kind || e.val != v || e.due != cyc) begin
            n_err++;
            $display("FAIL %s: kind=%0d val=%h cyc=%0d expected kind=%0d val=%h cyc=%0d",
                     e.req, kind, v, cyc, e.kind, e.val, e.due);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (ea_valid) compare(0, ea_addr);
            if (idx_we)   compare(1, idx_wdata);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
    end

    initial begin
        idle(3);
        // R1: reset state
        n_chk++;
        if (ea_valid !== 1'b0 || idx_we !== 1'b0) begin
            n_err++;
            $display("FAIL R1: ea_valid=%b idx_we=%b expected 0 0", ea_valid, idx_we);
        end
        rst = 1'b0;
        tick();
        cur_req = "R1";
        send(8'h11); send(8'h22);
        drained("R1");

        // R2, R6, R7: post-increment mode
        cur_req = "R6";
        idx_in = 16'h1234; stkp_in = 16'h0BAD;
        start_op(2'd1);
        send_last(8'h56, 16'h128A, "R2");
        send(8'h99);
        done_pulse(1, 16'h1235, "R7");
        drained("R6");

        // R3 and extra byte (R6)
        cur_req = "R6";
        idx_in = 16'h0100;
        start_op(2'd2);
        send(8'h12);
        idle(1);
        send_last(8'h34, 16'h1334, "R3");
        send(8'h77);
        cur_req = "R8";
        done_pulse(0, 16'h0, "R8");
        drained("R3");

        // R4: stack base
        cur_req = "R4";
        idx_in = 16'h4000; stkp_in = 16'h01F0;
        start_op(2'd3);
        send_last(8'h20, 16'h0210, "R4");
        done_pulse(0, 16'h0, "R8");
        drained("R4");

        // R5: wrap in offset-16 and in post-increment
        cur_req = "R5";
        idx_in = 16'hFF00;
        start_op(2'd2);
        send(8'h01);
        send_last(8'h20, 16'h0020, "R5");
        drained("R5");
        idx_in = 16'hFFFF;
        start_op(2'd1);
        send_last(8'h02, 16'h0001, "R5");
        done_pulse(1, 16'h0000, "R5");
        drained("R5");

        // R8: done before address issued
        cur_req = "R8";
        idx_in = 16'h3000;
        start_op(2'd1);
        done_pulse(0, 16'h0, "R8");
        idle(1);
        send_last(8'h04, 16'h3004, "R8");
        idle(2);
        done_pulse(1, 16'h3001, "R8");
        drained("R8");

        // R9: mode none
        cur_req = "R9";
        start_op(2'd0);
        send(8'h10); send(8'h20);
        done_pulse(0, 16'h0, "R9");
        drained("R9");

        // R10: byte with op_start not taken; restart abandons write-back
        cur_req = "R10";
        idx_in = 16'h0500;
        start_op(2'd1);
        op_start = 1'b1; op_mode = 2'd1; opnd_valid = 1'b1; opnd_byte = 8'h77;
        tick();
        op_start = 1'b0; opnd_valid = 1'b0;
        send_last(8'h05, 16'h0505, "R10");
        start_op(2'd3);
        done_pulse(0, 16'h0, "R10");
        drained("R10");

        // R7: captured index used even after idx_in changes
        cur_req = "R7";
        idx_in = 16'h2000;
        start_op(2'd1);
        send_last(8'h10, 16'h2010, "R7");
        idx_in = 16'h5555;
        idle(2);
        done_pulse(1, 16'h2001, "R7");
        done_pulse(0, 16'h0, "R7");
        drained("R7");

        summary();
    end

endmodule